// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

A bank of general-purpose input pins, each watched by its own trigger detector. Every pin has a configuration word. The word holds an output-enable flag, an interrupt-enable flag and a three-bit trigger mode. The mode selects one of five conditions on the synchronized pin value: level high, level low, rising edge, falling edge or any edge. A pin whose condition is met sets its bit in a shared pending register. Software clears pending bits by writing ones to that register.

The register port is a flat word-addressed space. Words 0 to NUM_PINS-1 are the per-pin configuration words. Word NUM_PINS is the pending register, and word NUM_PINS+1 returns the synchronized pin values. Each pin drives one interrupt line, which is its pending bit qualified by its interrupt-enable flag. Pad drive is handled elsewhere. The output-enable flag is only stored here and read back.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset, every configuration word reads 0, the pending register reads 0 and every irq_out line is 0.
- R2: A configuration word keeps bit 0 (output enable), bit 1 (interrupt enable) and bits 7:5 (trigger mode); all other bits read back as 0, so writing 0xFF reads back 0xE3.
- R3: Mode 0 (level high) sets the pin's pending bit on every cycle its synchronized input is 1, so a clear issued while the input stays high leaves the bit set.
- R4: Mode 1 (level low) sets the pending bit on every cycle the synchronized input is 0, and the bit can be cleared once the input is high.
- R5: Mode 2 (rising edge) sets the pending bit once per 0-to-1 transition of the synchronized input, and a steady high input does not set it again after a clear.
- R6: Mode 3 (falling edge) sets the pending bit on a 1-to-0 transition and ignores a 0-to-1 transition.
- R7: Mode 4 (both edges) sets the pending bit on either transition.
- R8: Mode codes 5, 6 and 7 never set the pending bit.
- R9: Writing the pending register (word NUM_PINS) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: If a pin's trigger fires in the same cycle that its pending bit is cleared, the bit stays set.
- R11: irq_out[n] is 1 exactly when pending bit n and the interrupt-enable flag of pin n are both 1; a pin with interrupt enable clear still records pending.
- R12: A pin change appears in the input register (word NUM_PINS+1) two clock edges after it is applied, and in the pending register on the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_out | output | NUM_PINS | Per-pin interrupt lines |

## Verification
The bench builds the block with NUM_PINS set to 8. With that value, a single pattern byte can carry all five trigger modes, two reserved codes and a pin with interrupts disabled. Each pending-register value then covers several modes at the same time. The narrow bank also puts the pending and input words at addresses 8 and 9. The bench can therefore check the two-edge and three-edge latencies one read per cycle, while the full 32-pin default is elaborated unchanged.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_W        = 32;
  localparam int CFG_OE_BIT   = 0;
  localparam int CFG_IE_BIT   = 1;
  localparam int CFG_MODE_LSB = 5;
  localparam int MODE_W       = 3;

  localparam logic [MODE_W-1:0] TRIG_LVL_HI = 3'd0;
  localparam logic [MODE_W-1:0] TRIG_LVL_LO = 3'd1;
  localparam logic [MODE_W-1:0] TRIG_RISE   = 3'd2;
  localparam logic [MODE_W-1:0] TRIG_FALL   = 3'd3;
  localparam logic [MODE_W-1:0] TRIG_BOTH   = 3'd4;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              ie;
    logic              oe;
  } pin_cfg_t;

  // Trigger condition for one pin, from current and previous synchronized value
  function automatic logic trig_hit(logic [MODE_W-1:0] mode, logic cur, logic prev);
    case (mode)
      TRIG_LVL_HI: trig_hit = cur;
      TRIG_LVL_LO: trig_hit = !cur;
      TRIG_RISE:   trig_hit = cur && !prev;
      TRIG_FALL:   trig_hit = !cur && prev;
      TRIG_BOTH:   trig_hit = cur ^ prev;
      default:     trig_hit = 1'b0;
    endcase
  endfunction

  function automatic logic mode_valid(logic [MODE_W-1:0] mode);
    mode_valid = (mode <= TRIG_BOTH);
  endfunction

  function automatic pin_cfg_t cfg_unpack(logic [REG_W-1:0] w);
    pin_cfg_t c;
    c.oe   = w[CFG_OE_BIT];
    c.ie   = w[CFG_IE_BIT];
    c.mode = w[CFG_MODE_LSB +: MODE_W];
    cfg_unpack = c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_pack(pin_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[CFG_OE_BIT]               = c.oe;
    w[CFG_IE_BIT]               = c.ie;
    w[CFG_MODE_LSB +: MODE_W]   = c.mode;
    cfg_pack = w;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur,
  input  logic [MODE_W-1:0] mode,
  output logic              hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign hit = trig_hit(mode, cur, prev_q);
endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_PINS = 32,
  localparam int ADDR_W   = $clog2(NUM_PINS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  output logic [NUM_PINS-1:0] irq_out
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] IN_ADDR   = ADDR_W'(NUM_PINS + 1);

  pin_cfg_t            cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0] sync_v;
  logic [NUM_PINS-1:0] det_vec;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] ie_vec;
  logic [NUM_PINS-1:0] mode_ok_vec;
  logic [NUM_PINS-1:0] pend_q;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (sync_v)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[p] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(p))
        cfg_q[p] <= cfg_unpack(wr_data);
    end

    gpio_pin_detect u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (sync_v[p]),
      .mode  (cfg_q[p].mode),
      .hit   (det_vec[p])
    );

    assign ie_vec[p]      = cfg_q[p].ie;
    assign mode_ok_vec[p] = mode_valid(cfg_q[p].mode);
  end

  assign clr_vec = (wr_en && wr_addr == STAT_ADDR) ? wr_data[NUM_PINS-1:0] : '0;

  // Set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | det_vec;
  end

  assign irq_out = pend_q & ie_vec;

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (rd_addr == ADDR_W'(p)) rd_data = cfg_pack(cfg_q[p]);
    if (rd_addr == STAT_ADDR) rd_data[NUM_PINS-1:0] = pend_q;
    if (rd_addr == IN_ADDR)   rd_data[NUM_PINS-1:0] = sync_v;
  end
endmodule

module gpio_irq_detector_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] det_vec,
  input logic [N-1:0] clr_vec,
  input logic [N-1:0] mode_ok_vec
);
  // R1: pending register is empty on the first cycle out of reset
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend_q == '0));

  // R8: reserved mode codes never produce a trigger
  p_reserved_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (det_vec & ~mode_ok_vec) == '0);

  // R9: a clear without a coincident trigger empties the bit
  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~det_vec) != '0) |=> ((pend_q & $past(clr_vec & ~det_vec)) == '0));

  // R9: bits that were neither set nor cleared keep their value
  p_untouched_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_q ^ $past(pend_q)) & ~$past(clr_vec | det_vec)) == '0));

  // R10: a trigger always lands, even against a clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (det_vec != '0) |=> ((pend_q & $past(det_vec)) == $past(det_vec)));
endmodule

bind gpio_irq_detector gpio_irq_detector_chk #(.N(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pend_q      (pend_q),
  .det_vec     (det_vec),
  .clr_vec     (clr_vec),
  .mode_ok_vec (mode_ok_vec)
);

// File: tb/gpio_irq_detector_bench.sv
module gpio_irq_detector_bench;
  localparam int NP = 8;
  localparam int AW = $clog2(NP + 2);
  localparam logic [AW-1:0] A_STAT = AW'(NP);
  localparam logic [AW-1:0] A_IN   = AW'(NP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] irq_out;

  always #4ns clk = ~clk;

  gpio_irq_detector #(.NUM_PINS(NP)) u_gpio_irq_detector (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? 32'(irq_out) : rd_data;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1ns;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    tick();
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_pins(logic [NP-1:0] v);
    tick();
    pin_in = v;
  endtask

  task automatic exp_rd(logic [AW-1:0] a, logic [31:0] e, string tag);
    item_t it;
    tick();
    rd_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_irq(logic [NP-1:0] e, string tag);
    item_t it;
    tick();
    it.is_irq = 1'b1; it.exp = 32'(e); it.tag = tag;
    q.push_back(it);
  endtask

  function automatic logic [31:0] cfg(logic [2:0] mode, bit ie);
    return (32'(mode) << 5) | (32'(ie) << 1);
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    exp_rd(3, 32'h0, "R1 cfg word");
    exp_rd(A_STAT, 32'h0, "R1 pending");
    exp_irq('0, "R1 irq");

    // R2 field masking
    wr(1, 32'hFFFF_FFFF & 32'hFF);
    exp_rd(1, 32'hE3, "R2 mask readback");

    // Pins: 0 rise, 1 fall, 2 both, 3 lvl hi, 4 lvl lo, 5 code5, 6 code7, 7 rise no IE
    wr(0, cfg(3'd2, 1)); wr(1, cfg(3'd3, 1)); wr(2, cfg(3'd4, 1)); wr(3, cfg(3'd0, 1));
    wr(4, cfg(3'd1, 1)); wr(5, cfg(3'd5, 1)); wr(6, cfg(3'd7, 1)); wr(7, cfg(3'd2, 0));
    exp_rd(0, 32'h42, "R2 cfg readback");

    // R4/R10: level-low pin 4 re-sets against the clear
    wr(A_STAT, 32'hFF);
    exp_rd(A_STAT, 32'h10, "R10 set beats clear");
    exp_irq(8'h10, "R11 irq level low");

    // R12/R5 latency on rising pin 0
    set_pins(8'h01);
    exp_rd(A_IN, 32'h00, "R12 input after 1 edge");
    exp_rd(A_STAT, 32'h10, "R12 pending after 2 edges");
    exp_rd(A_STAT, 32'h11, "R12 pending after 3 edges");
    exp_rd(A_IN, 32'h01, "R12 input value");

    // R5/R9 clear one bit, steady high gives no new set
    wr(A_STAT, 32'h01);
    idle(4);
    exp_rd(A_STAT, 32'h10, "R5 no retrigger on steady high");

    // R11 pending without enable, R9 zero bits untouched
    set_pins(8'h81);
    idle(4);
    exp_rd(A_STAT, 32'h90, "R11 pending recorded without IE");
    exp_irq(8'h10, "R11 irq gated by IE");
    wr(A_STAT, 32'h01);
    exp_rd(A_STAT, 32'h90, "R9 zero bits leave pending");

    // R6 falling on pin 1
    set_pins(8'h83);
    idle(4);
    exp_rd(A_STAT, 32'h90, "R6 rise ignored");
    set_pins(8'h81);
    idle(4);
    exp_rd(A_STAT, 32'h92, "R6 fall sets");

    // R7 both edges on pin 2
    set_pins(8'h85);
    idle(4);
    exp_rd(A_STAT, 32'h96, "R7 rise sets");
    wr(A_STAT, 32'h04);
    exp_rd(A_STAT, 32'h92, "R9 clear pin 2");
    set_pins(8'h81);
    idle(4);
    exp_rd(A_STAT, 32'h96, "R7 fall sets");

    // R3 level high on pin 3
    set_pins(8'h89);
    idle(4);
    wr(A_STAT, 32'h08);
    exp_rd(A_STAT, 32'h9E, "R3 clear while high does not stick");
    exp_irq(8'h1E, "R11 irq mix");
    set_pins(8'h81);
    idle(4);
    wr(A_STAT, 32'h08);
    exp_rd(A_STAT, 32'h96, "R3 clear after level drops");

    // R4 level low released
    set_pins(8'h91);
    idle(4);
    wr(A_STAT, 32'h10);
    exp_rd(A_STAT, 32'h86, "R4 clear once input high");

    // R8 reserved codes on pins 5,6
    set_pins(8'hF1);
    idle(4);
    set_pins(8'h91);
    idle(4);
    exp_rd(A_STAT, 32'h86, "R8 reserved codes silent");

    wr(A_STAT, 32'hFF);
    idle(3);
    exp_rd(A_STAT, 32'h00, "R9 full clear");
    exp_irq('0, "R11 irq idle");
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule